// File: doc/BRIEF.md
# Stereo Soft-Ramp Attenuator with Mute

This block scales a stream of signed 16-bit stereo samples by a gain taken from an 8-bit attenuation setting. An internal 9-bit gain counter holds a value from 0 to 256, where 256 is unity gain. Each time a sample is accepted, the counter moves one step toward its goal. A new setting therefore fades in instead of producing a click. A full swing across the range takes 256 samples, which is about 5.8 ms at 44.1 kHz.

A controller drives the enable, level and mute fields. There are three mute sources. A soft-mute flag and an external mute pin both fade the gain down to zero. Once both are released, the counter jumps straight back to its target. A forced-mute input zeroes the output samples at once and leaves the counter alone. Each output sample is the product of the input sample and the counter, shifted right arithmetically by eight bits. It is presented one clock after its input strobe.

Top module: `soft_attenuator`

## Requirements
- R1: After reset, out_valid and out_data are 0 and the gain counter is 256 (unity).
- R2: For each clock with in_valid high, one clock later out_valid is high and each channel of out_data equals floor(sample × G / 256). Here G is the counter value before that clock's update and the sample is signed. Channel 0 occupies bits [15:0] and channel 1 bits [31:16].
- R3: With att_en at 0 the target gain is 256, so once the counter is at 256 the samples pass through unchanged. With att_en at 1 the target is att_level (0 to 255).
- R4: On each accepted sample the counter moves by exactly one toward its goal, or stays put once it equals the goal. It never changes on a clock without in_valid, except for the release in R6.
- R5: While soft_mute or ext_mute is 1, the goal is 0 and the counter falls by one per accepted sample.
- R6: On the first clock where soft_mute and ext_mute are both 0 after either of them was 1, the counter loads the target directly, whether or not a sample is accepted.
- R7: A sample accepted while force_mute is 1 yields 0 on both channels. The counter keeps stepping as if force_mute were 0.
- R8: On a clock without in_valid, out_valid falls to 0 and out_data holds its value.
- R9: Starting from 256, a soft mute reaches gain 0 after exactly 256 accepted samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Sample strobe, one clock per stereo sample |
| in_data | input | 32 | Stereo input sample, channel 1 in the upper half |
| att_en | input | 1 | 1 selects att_level as target, 0 selects unity |
| att_level | input | 8 | Attenuation target, 0 to 255 |
| force_mute | input | 1 | Zeroes output samples immediately |
| soft_mute | input | 1 | Fades the gain to zero |
| ext_mute | input | 1 | External mute pin, same effect as soft_mute |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | 32 | Scaled stereo output sample |

## Verification
The clocked properties assume that the control inputs change only on clock edges and are synchronous to clk. They also assume that the sample strobe carries at most one sample per clock. The stimulus respects this by driving every input on the falling edge. Controls change between random runs of samples and idle clocks, and mute releases are placed both on clocks with a sample and on clocks without one. Directed cases are mixed in: extreme sample values, a full-scale fade down and an instant return.

// File: rtl/sattn_pkg.sv
package sattn_pkg;
  // Operation chosen for the gain counter in one clock
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_UP   = 2'd1,
    OP_DOWN = 2'd2,
    OP_LOAD = 2'd3
  } ramp_op_e;
endpackage

// File: rtl/sattn_rst_sync.sv
module sattn_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      rst_ns <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      rst_ns <= meta_q;
    end
  end
endmodule

// File: rtl/sattn_gain_ramp.sv
module sattn_gain_ramp
  import sattn_pkg::*;
#(
  parameter int GW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          att_en,
  input  logic [GW-1:0] level,
  input  logic          mute,
  output logic [GW:0]   gain
);
  localparam int CW = GW + 1;
  localparam logic [CW-1:0] FULL = {1'b1, {GW{1'b0}}};

  logic [CW-1:0] target, goal, gain_d;
  logic          mute_q, rel;
  ramp_op_e      op;

  always_comb begin
    target = att_en ? {1'b0, level} : FULL;
    goal   = mute ? '0 : target;
    rel    = mute_q & ~mute;
    if (rel)                       op = OP_LOAD;
    else if (step && gain < goal)  op = OP_UP;
    else if (step && gain > goal)  op = OP_DOWN;
    else                           op = OP_HOLD;
    unique case (op)
      OP_LOAD: gain_d = target;
      OP_UP:   gain_d = gain + 1'b1;
      OP_DOWN: gain_d = gain - 1'b1;
      default: gain_d = gain;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gain   <= FULL;
      mute_q <= 1'b0;
    end else begin
      gain   <= gain_d;
      mute_q <= mute;
    end
  end

  p_one_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    step && !rel |=> (gain == $past(gain)) || (gain == $past(gain) + 1'b1)
                     || (gain + 1'b1 == $past(gain)));
  p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !step && !rel |=> $stable(gain));
  p_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    gain <= FULL);
  p_fade_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
    step && mute && gain != '0 |=> gain + 1'b1 == $past(gain));
  p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rel |=> gain == $past(target));
endmodule

// File: rtl/sattn_mul.sv
module sattn_mul #(
  parameter int DW = 16,
  parameter int GW = 8
) (
  input  logic [DW-1:0] smp,
  input  logic [GW:0]   gain,
  input  logic          zero,
  output logic [DW-1:0] res
);
  localparam int PW = DW + GW + 2;

  logic signed [PW-1:0] prod;

  always_comb begin
    prod = PW'($signed(smp)) * PW'($signed({1'b0, gain}));
    res  = zero ? '0 : prod[GW +: DW];
  end
endmodule

// File: rtl/soft_attenuator.sv
module soft_attenuator #(
  parameter int DW  = 16,
  parameter int GW  = 8,
  parameter int NCH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [NCH*DW-1:0] in_data,
  input  logic              att_en,
  input  logic [GW-1:0]     att_level,
  input  logic              force_mute,
  input  logic              soft_mute,
  input  logic              ext_mute,
  output logic              out_valid,
  output logic [NCH*DW-1:0] out_data
);
  localparam int TW = NCH * DW;

  logic          rst_ns;
  logic [GW:0]   gain;
  logic [TW-1:0] scaled, out_d;
  logic          vld_d;

  sattn_rst_sync u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_ns(rst_ns)
  );

  sattn_gain_ramp #(.GW(GW)) u_ramp (
    .clk   (clk),
    .rst_n (rst_ns),
    .step  (in_valid),
    .att_en(att_en),
    .level (att_level),
    .mute  (soft_mute | ext_mute),
    .gain  (gain)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    sattn_mul #(.DW(DW), .GW(GW)) u_mul (
      .smp (in_data[c*DW +: DW]),
      .gain(gain),
      .zero(force_mute),
      .res (scaled[c*DW +: DW])
    );
  end

  always_comb begin
    vld_d = in_valid;
    out_d = in_valid ? scaled : out_data;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= vld_d;
      out_data  <= out_d;
    end
  end

  p_strobe_r2: assert property (@(posedge clk) disable iff (!rst_ns)
    in_valid |=> out_valid);
  p_force_zero_r7: assert property (@(posedge clk) disable iff (!rst_ns)
    in_valid && force_mute |=> out_data == '0);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_ns)
    !in_valid |=> !out_valid && $stable(out_data));
endmodule

// File: tb/sim_soft_attenuator.sv
module sim_soft_attenuator;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic        att_en = 1'b0;
  logic [7:0]  att_level = '0;
  logic        force_mute = 1'b0;
  logic        soft_mute = 1'b0;
  logic        ext_mute = 1'b0;
  logic        out_valid;
  logic [31:0] out_data;

  int checks = 0;
  int errors = 0;
  int g_model = 256;
  bit mute_prev = 1'b0;
  logic [31:0] last_out = '0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  soft_attenuator u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .att_en(att_en), .att_level(att_level), .force_mute(force_mute),
    .soft_mute(soft_mute), .ext_mute(ext_mute),
    .out_valid(out_valid), .out_data(out_data)
  );

  function automatic logic [15:0] scale(input logic [15:0] s, input int g);
    int p;
    p = int'($signed(s)) * g;
    return 16'(p >>> 8);
  endfunction

  task automatic check(input string tag, input logic [32:0] act, input logic [32:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // one clock: drive at falling edge, model, then compare after rising edge
  task automatic cyc(input string tag, input bit v, input logic [15:0] l, input logic [15:0] r);
    logic [31:0] exp;
    int tgt;
    bit m;
    in_valid = v;
    in_data  = {r, l};
    exp = last_out;
    if (v) exp = force_mute ? 32'h0 : {scale(r, g_model), scale(l, g_model)};
    m   = soft_mute | ext_mute;
    tgt = att_en ? int'(att_level) : 256;
    if (mute_prev && !m) g_model = tgt;
    else if (v) begin
      if (m) tgt = 0;
      if (g_model < tgt) g_model++;
      else if (g_model > tgt) g_model--;
    end
    mute_prev = m;
    @(posedge clk);
    #1;
    check(tag, {out_valid, out_data}, {v, exp});
    last_out = exp;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1 reset", {out_valid, out_data}, 33'h0);
    rst_n = 1'b1;
    repeat (3) cyc("R1 idle after reset", 1'b0, 16'h0, 16'h0);
    // R1/R3 unity passthrough from reset
    cyc("R1 unity gain", 1'b1, 16'h1234, 16'hFEDC);
    cyc("R3 bypass max", 1'b1, 16'h7FFF, 16'h8000);
    cyc("R3 bypass min", 1'b1, 16'h8000, 16'hFFFF);
    // R4 ramp toward enabled level
    att_en = 1'b1; att_level = 8'hF0;
    for (int i = 0; i < 20; i++) cyc("R4 ramp down", 1'b1, 16'h7FFF, 16'h8001);
    cyc("R8 hold", 1'b0, 16'h5555, 16'h5555);
    cyc("R4 idle no step", 1'b0, 16'h0, 16'h0);
    att_level = 8'h80;
    for (int i = 0; i < 120; i++) cyc("R2 negative floor", 1'b1, 16'hFFFF, 16'h0003);
    // R5/R9 soft fade from unity
    att_en = 1'b0;
    for (int i = 0; i < 130; i++) cyc("R3 back to unity", 1'b1, 16'h4000, 16'hC000);
    soft_mute = 1'b1;
    for (int i = 0; i < 256; i++) cyc("R9 full fade", 1'b1, 16'h7FFF, 16'h8000);
    cyc("R9 gain zero", 1'b1, 16'h7FFF, 16'h8000);
    check("R9 reached zero", {1'b0, last_out}, 33'h0);
    // R6 release on an idle clock
    soft_mute = 1'b0;
    cyc("R6 release idle", 1'b0, 16'h0, 16'h0);
    cyc("R6 instant return", 1'b1, 16'h7FFF, 16'h8000);
    check("R6 full scale", {1'b0, last_out}, {1'b0, 16'h8000, 16'h7FFF});
    // R5 external pin, release on a sample clock
    ext_mute = 1'b1;
    for (int i = 0; i < 10; i++) cyc("R5 pin fade", 1'b1, 16'h0100, 16'hFF00);
    ext_mute = 1'b0;
    cyc("R6 release on sample", 1'b1, 16'h0100, 16'hFF00);
    cyc("R6 after release", 1'b1, 16'h0100, 16'hFF00);
    // R7 force mute, counter still ramps
    att_en = 1'b1; att_level = 8'h40;
    force_mute = 1'b1;
    for (int i = 0; i < 8; i++) cyc("R7 forced zero", 1'b1, 16'h7FFF, 16'h8000);
    force_mute = 1'b0;
    cyc("R7 counter kept ramping", 1'b1, 16'h7FFF, 16'h8000);
    // R2 random mix
    for (int blk = 0; blk < 60; blk++) begin
      att_en     = ($urandom % 4) != 0;
      att_level  = 8'($urandom);
      soft_mute  = ($urandom % 4) == 0;
      ext_mute   = ($urandom % 8) == 0;
      force_mute = ($urandom % 8) == 0;
      for (int i = 0; i < 40; i++)
        cyc("R2 random", ($urandom % 4) != 0, 16'($urandom), 16'($urandom));
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule